// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This controller sits between a 16-bit processor bus and slow main memory. It keeps a copy of recently read words in a small direct-mapped store. Each address is split in two. The low bits select one entry, and the high bits (the page number) are kept in a tag beside that entry. A cacheable read whose entry is valid and whose tag matches is answered from the store. It is acknowledged in the cycle after the request, and the memory strobe is never raised. Any other access goes to memory. The controller holds the memory strobe until memory signals ready, then acknowledges in the following cycle. On a cacheable read miss, the returned word and its page number are written into the entry at that moment.

Writes always go through to memory and always pay the memory latency. A write to a cached, matching entry also refreshes that entry. A write that misses leaves the store unchanged. A per-access cacheable flag lets I/O space bypass the store, so such an access never hits and never fills.

The sequencer has four states, IDLE, LOOKUP, MEMWAIT and COMPLETE, with these transitions:
- IDLE goes to LOOKUP when a request pulse arrives.
- LOOKUP goes back to IDLE on a cacheable read hit. It goes to MEMWAIT in every other case.
- MEMWAIT goes to COMPLETE when memory is ready.
- COMPLETE goes to IDLE.

Top module: `dmcache_ctrl`

## Requirements
- R1: After reset every entry is invalid, so the first read of any address is served by memory (acknowledge 5 cycles after the request pulse when memory is ready 3 cycles into the strobe). Out of reset, cpu_ack and mem_strobe are low.
- R2: A cacheable read hit raises cpu_ack for one cycle, one cycle after the request pulse, with the stored word on cpu_rdata. mem_strobe stays low for the whole access.
- R3: On a read miss, mem_strobe rises the cycle after lookup with mem_rw=1 and mem_addr equal to the request address. It is held until mem_ready is seen. cpu_ack pulses the next cycle, carrying the word memory returned.
- R4: A cacheable read miss fills the entry, so a repeat read of the same address hits.
- R5: The entry is selected by the low INDEX_W address bits. A filled address whose entry is then filled by another address with the same low bits and different high bits misses again.
- R6: Every write (cpu_rw=0) strobes memory with mem_rw=0, the request address and data, and is acknowledged the cycle after mem_ready, whether or not it hits.
- R7: A cacheable write that hits updates the stored word, and a following read hits with the new value.
- R8: A write that misses does not allocate, so a following read of that address misses.
- R9: An access with cpu_cacheable=0 never hits, even when a matching valid entry exists, and never fills an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_as | input | 1 | One-cycle request pulse; address, data, direction and flag are sampled with it |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_cacheable | input | 1 | 1 = access may use the cache |
| cpu_addr | input | ADDR_W (16) | Word address |
| cpu_wdata | input | DATA_W (16) | Write data |
| cpu_rdata | output | DATA_W (16) | Read data, valid while cpu_ack is high on a read |
| cpu_ack | output | 1 | One-cycle completion pulse |
| mem_strobe | output | 1 | Memory cycle request, held until mem_ready |
| mem_rw | output | 1 | 1 = memory read, 0 = memory write |
| mem_addr | output | ADDR_W (16) | Memory address |
| mem_wdata | output | DATA_W (16) | Memory write data |
| mem_rdata | input | DATA_W (16) | Memory read data, sampled with mem_ready |
| mem_ready | input | 1 | Memory completion, valid while mem_strobe is high |

## Verification
Repeated reads of one address separate hit timing from miss timing. Pairs of addresses that share low bits but differ in page number show that entries are displaced rather than kept side by side. Writes to cached and uncached addresses, each followed by a read, show whether a write refreshes or allocates an entry. Uncacheable reads of an address that is already cached show that the bypass overrides a matching tag. A pseudo-random address sweep, with every address read twice, covers many index and tag combinations against the bench's own model of the store.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LOOKUP   = 2'd1,
        ST_MEMWAIT  = 2'd2,
        ST_COMPLETE = 2'd3
    } dmc_state_e;

endpackage

// File: rtl/dmc_tag_store.sv
// Valid bits and page numbers, one per entry. Valid bits reset to zero.
module dmc_tag_store #(
    parameter int INDEX_W = 6,
    parameter int TAG_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_index,
    output logic               rd_valid,
    output logic [TAG_W-1:0]   rd_tag,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [TAG_W-1:0]   wr_tag
);
    localparam int DEPTH = 1 << INDEX_W;

    logic [DEPTH-1:0] valid_bits;
    logic [TAG_W-1:0] tag_mem [DEPTH];

    // one valid flop per entry, set when its entry is written
    for (genvar e = 0; e < DEPTH; e++) begin : g_valid
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_bits[e] <= 1'b0;
            end else if (wr_en && (wr_index == INDEX_W'(e))) begin
                valid_bits[e] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_index] <= wr_tag;
        end
    end

    always_comb begin
        rd_valid = valid_bits[rd_index];
        rd_tag   = tag_mem[rd_index];
    end

endmodule

// File: rtl/dmc_data_store.sv
// Word storage, one word per entry, read combinationally.
module dmc_data_store #(
    parameter int INDEX_W = 6,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic [INDEX_W-1:0] rd_index,
    output logic [DATA_W-1:0]  rd_data,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  logic [DATA_W-1:0]  wr_data
);
    localparam int DEPTH = 1 << INDEX_W;

    logic [DATA_W-1:0] word_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_mem[wr_index] <= wr_data;
        end
    end

    assign rd_data = word_mem[rd_index];

endmodule

// File: rtl/dmc_fsm.sv
// Access sequencer: IDLE -> LOOKUP -> (IDLE | MEMWAIT -> COMPLETE -> IDLE)
module dmc_fsm
    import dmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_pulse,
    input  logic       req_read,
    input  logic       req_cache,
    input  logic       tag_hit,
    input  logic       mem_ready,
    output dmc_state_e state,
    output logic       load_req,
    output logic       cap_mem,
    output logic       ack,
    output logic       strobe,
    output logic       fill_we,
    output logic       update_we,
    output logic       serve_hit
);
    dmc_state_e nxt;

    logic cached_read_hit;
    assign cached_read_hit = req_read && req_cache && tag_hit;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req_pulse)       nxt = ST_LOOKUP;
            ST_LOOKUP:   if (cached_read_hit) nxt = ST_IDLE;
                         else                 nxt = ST_MEMWAIT;
            ST_MEMWAIT:  if (mem_ready)       nxt = ST_COMPLETE;
            ST_COMPLETE:                      nxt = ST_IDLE;
            default:                          nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // outputs
    always_comb begin
        load_req  = 1'b0;
        cap_mem   = 1'b0;
        ack       = 1'b0;
        strobe    = 1'b0;
        fill_we   = 1'b0;
        update_we = 1'b0;
        serve_hit = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load_req = req_pulse;
            end
            ST_LOOKUP: begin
                if (cached_read_hit) begin
                    ack       = 1'b1;
                    serve_hit = 1'b1;
                end
            end
            ST_MEMWAIT: begin
                strobe  = 1'b1;
                cap_mem = mem_ready;
            end
            ST_COMPLETE: begin
                ack       = 1'b1;
                fill_we   = req_read && req_cache;
                update_we = !req_read && req_cache && tag_hit;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dmcache_ctrl.sv
module dmcache_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int INDEX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_as,
    input  logic              cpu_rw,
    input  logic              cpu_cacheable,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              mem_strobe,
    output logic              mem_rw,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    dmc_state_e state;

    logic [ADDR_W-1:0]  req_addr;
    logic [DATA_W-1:0]  req_wdata;
    logic               req_read;
    logic               req_cache;
    logic [DATA_W-1:0]  mem_word_q;

    logic [INDEX_W-1:0] req_index;
    logic [TAG_W-1:0]   req_tag;
    logic               ent_valid;
    logic [TAG_W-1:0]   ent_tag;
    logic [DATA_W-1:0]  ent_data;
    logic               tag_hit;

    logic load_req, cap_mem, fill_we, update_we, serve_hit;
    logic store_we;
    logic [DATA_W-1:0] store_wdata;

    assign req_index = req_addr[INDEX_W-1:0];
    assign req_tag   = req_addr[ADDR_W-1:INDEX_W];
    assign tag_hit   = ent_valid && (ent_tag == req_tag);

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr  <= '0;
            req_wdata <= '0;
            req_read  <= 1'b1;
            req_cache <= 1'b0;
        end else if (load_req) begin
            req_addr  <= cpu_addr;
            req_wdata <= cpu_wdata;
            req_read  <= cpu_rw;
            req_cache <= cpu_cacheable;
        end
    end

    // memory word capture on ready
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_word_q <= '0;
        end else if (cap_mem) begin
            mem_word_q <= mem_rdata;
        end
    end

    dmc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_pulse (cpu_as),
        .req_read  (req_read),
        .req_cache (req_cache),
        .tag_hit   (tag_hit),
        .mem_ready (mem_ready),
        .state     (state),
        .load_req  (load_req),
        .cap_mem   (cap_mem),
        .ack       (cpu_ack),
        .strobe    (mem_strobe),
        .fill_we   (fill_we),
        .update_we (update_we),
        .serve_hit (serve_hit)
    );

    // a fill writes tag and word; a write hit rewrites the word only
    assign store_we    = fill_we || update_we;
    assign store_wdata = fill_we ? mem_word_q : req_wdata;

    dmc_tag_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_index (req_index),
        .rd_valid (ent_valid),
        .rd_tag   (ent_tag),
        .wr_en    (fill_we),
        .wr_index (req_index),
        .wr_tag   (req_tag)
    );

    dmc_data_store #(
        .INDEX_W (INDEX_W),
        .DATA_W  (DATA_W)
    ) u_data (
        .clk      (clk),
        .rd_index (req_index),
        .rd_data  (ent_data),
        .wr_en    (store_we),
        .wr_index (req_index),
        .wr_data  (store_wdata)
    );

    assign cpu_rdata = serve_hit ? ent_data : mem_word_q;
    assign mem_rw    = req_read;
    assign mem_addr  = req_addr;
    assign mem_wdata = req_wdata;

endmodule

// File: rtl/dmcache_ctrl_chk.sv
module dmcache_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_as,
    input logic cpu_rw,
    input logic cpu_cacheable,
    input logic cpu_ack,
    input logic mem_strobe,
    input logic mem_ready
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);                                        // R2
    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !$past(mem_strobe)) |-> $past(cpu_as));           // R2
    AST_STROBE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && !mem_ready) |=> mem_strobe);                   // R3
    AST_READY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && mem_ready) |=> (cpu_ack && !mem_strobe));      // R3
    AST_WRITE_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_as && !cpu_rw) |=> !cpu_ack);                            // R6
    AST_BYPASS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_as && !cpu_cacheable) |=> !cpu_ack);                     // R9
endmodule

bind dmcache_ctrl dmcache_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_as        (cpu_as),
    .cpu_rw        (cpu_rw),
    .cpu_cacheable (cpu_cacheable),
    .cpu_ack       (cpu_ack),
    .mem_strobe    (mem_strobe),
    .mem_ready     (mem_ready)
);

// File: tb/dmcache_ctrl_test.sv
module dmcache_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_as = 1'b0;
    logic        cpu_rw = 1'b1;
    logic        cpu_cacheable = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ack;
    logic        mem_strobe;
    logic        mem_rw;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    int checks = 0;
    int fails  = 0;

    // behavioural model: memory contents and cache lines keyed by index
    logic [15:0] mem_store [logic [15:0]];
    logic [9:0]  ref_tag   [int];
    logic [15:0] ref_data  [int];

    always #4 clk = ~clk;  // 125 MHz

    dmcache_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_as        (cpu_as),
        .cpu_rw        (cpu_rw),
        .cpu_cacheable (cpu_cacheable),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_rdata     (cpu_rdata),
        .cpu_ack       (cpu_ack),
        .mem_strobe    (mem_strobe),
        .mem_rw        (mem_rw),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rdata     (mem_rdata),
        .mem_ready     (mem_ready)
    );

    function automatic logic [15:0] mem_read(input logic [15:0] a);
        if (mem_store.exists(a)) return mem_store[a];
        return 16'((a * 16'h03B1) ^ 16'h5A5A);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic access(input bit rd, input logic [15:0] a, input logic [15:0] wd,
                          input bit cach, input string req, output int lat);
        int          idx;
        logic [9:0]  tg;
        bit          exp_hit;
        logic [15:0] exp_word;
        int          wcnt;
        bit          e_ack;
        bit          e_str;
        idx = int'(a[5:0]);
        tg  = a[15:6];
        exp_hit  = cach && rd && ref_tag.exists(idx) && (ref_tag[idx] == tg);
        exp_word = exp_hit ? ref_data[idx] : mem_read(a);
        @(negedge clk);
        cpu_as = 1'b1; cpu_rw = rd; cpu_addr = a; cpu_wdata = wd; cpu_cacheable = cach;
        lat = 0;
        wcnt = 0;
        for (int p = 1; p <= 12 && lat == 0; p++) begin
            @(negedge clk);
            cpu_as = 1'b0;
            mem_ready = 1'b0;
            if (mem_strobe) begin
                wcnt++;
                if (wcnt == 3) begin
                    mem_ready = 1'b1;
                    check(mem_addr == a && mem_rw == rd, req, "memory address/direction",
                          {15'd0, mem_rw, mem_addr}, {15'd0, rd, a});
                    if (mem_rw) begin
                        mem_rdata = mem_read(mem_addr);
                    end else begin
                        check(mem_wdata == wd, "R6", "write-through data", mem_wdata, wd);
                        mem_store[mem_addr] = mem_wdata;
                    end
                end
            end
            e_ack = exp_hit ? (p == 1) : (p == 5);
            e_str = !exp_hit && p >= 2 && p <= 4;
            check(cpu_ack === e_ack && mem_strobe === e_str, req, $sformatf("ack/strobe phase %0d", p),
                  {30'd0, cpu_ack, mem_strobe}, {30'd0, e_ack, e_str});
            if (cpu_ack) begin
                lat = p;
                if (rd) check(cpu_rdata === exp_word, req, "read data", cpu_rdata, exp_word);
            end
        end
        if (lat == 0) check(1'b0, req, "access never acknowledged", 0, 1);
        if (cach && rd) begin
            ref_tag[idx]  = tg;
            ref_data[idx] = exp_word;
        end else if (cach && !rd && ref_tag.exists(idx) && ref_tag[idx] == tg) begin
            ref_data[idx] = wd;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int lat;
        logic [15:0] lcg;
        repeat (4) @(negedge clk);
        check(cpu_ack === 1'b0 && mem_strobe === 1'b0, "R1", "outputs in reset",
              {cpu_ack, mem_strobe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_ack === 1'b0 && mem_strobe === 1'b0, "R1", "outputs after reset",
              {cpu_ack, mem_strobe}, 0);

        access(1, 16'h0010, 0, 1, "R1", lat);
        check(lat == 5, "R1", "first read misses", lat, 5);
        access(1, 16'h0010, 0, 1, "R2", lat);
        check(lat == 1, "R4", "repeat read hits", lat, 1);

        access(1, 16'h0050, 0, 1, "R3", lat);
        check(lat == 5, "R5", "same index other page misses", lat, 5);
        access(1, 16'h0010, 0, 1, "R5", lat);
        check(lat == 5, "R5", "displaced address misses", lat, 5);

        access(0, 16'h0010, 16'hBEEF, 1, "R6", lat);
        check(lat == 5, "R6", "write hit pays memory latency", lat, 5);
        access(1, 16'h0010, 0, 1, "R7", lat);
        check(lat == 1, "R7", "read after write hit hits", lat, 1);

        access(0, 16'h0123, 16'h1234, 1, "R6", lat);
        check(lat == 5, "R6", "write miss latency", lat, 5);
        access(1, 16'h0123, 0, 1, "R8", lat);
        check(lat == 5, "R8", "write miss did not allocate", lat, 5);

        access(1, 16'h0010, 0, 0, "R9", lat);
        check(lat == 5, "R9", "uncacheable read of cached address", lat, 5);
        access(1, 16'h0200, 0, 0, "R9", lat);
        check(lat == 5, "R9", "uncacheable read", lat, 5);
        access(1, 16'h0200, 0, 1, "R9", lat);
        check(lat == 5, "R9", "uncacheable read did not fill", lat, 5);

        lcg = 16'h1D37;
        for (int i = 0; i < 40; i++) begin
            lcg = 16'(lcg * 16'd25173 + 16'd13849);
            access(1, lcg, 0, 1, "R3", lat);
            access(1, lcg, 0, 1, "R2", lat);
            check(lat == 1, "R4", "sweep repeat read hits", lat, 1);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule